// File: doc/BRIEF.md
# Handshaked Memory Access Requester

This block sits on the processor side of a memory port that works in two phases. A load or store command arrives on a valid/ready command interface. The block first asks for the memory with a request line and holds it until the memory grants access. It then keeps the transaction (address, one read or write strobe, store data) steady until the memory signals completion. The memory may grant access in the same cycle the request appears. With zero latency it may also complete in that same cycle. Any number of wait cycles may come before the grant and between the grant and completion.

On a load, the word on the memory read-data bus is captured in the completion cycle and handed back on the next cycle with a single-cycle response valid. Stores return nothing. Only one transaction is ever outstanding. The controller has three states:
- `ST_IDLE` ready for a command.
- `ST_REQUEST` request raised, waiting for grant.
- `ST_TRANSFER` granted, waiting for completion.

The transitions are:
- ACCEPT: `ST_IDLE`→`ST_REQUEST` when a command is valid.
- GRANT_WAIT: stay in `ST_REQUEST` while no acknowledge arrives.
- GRANT: `ST_REQUEST`→`ST_TRANSFER` on acknowledge without done.
- FAST_FINISH: `ST_REQUEST`→`ST_IDLE` on acknowledge together with done.
- DONE_WAIT: stay in `ST_TRANSFER` while done is low.
- FINISH: `ST_TRANSFER`→`ST_IDLE` on done.

Top module: `mem_access_requester`

## Requirements
- R1: `cmd_ready` is 1 only in the idle state. A command is taken only at a rising edge where `cmd_valid` and `cmd_ready` are both 1. While a transaction is in progress, `cmd_ready` stays 0.
- R2: `mem_req` rises in the cycle after a command is taken and stays 1 in every cycle until and including the cycle with `mem_acq` = 1. It drops after that.
- R3: From the first request cycle until and including the done cycle, `mem_addr`, `mem_rd`, `mem_wr` and `mem_wdata` are driven with the command's values and do not change.
- R4: A store (`cmd_write` = 1) raises only `mem_wr`. A load (`cmd_write` = 0) raises only `mem_rd`. The two strobes are never 1 together.
- R5: When `mem_acq` and `mem_done` are both 1 in the first request cycle, the transaction completes in that cycle.
- R6: Any number of cycles without acknowledge, and any number of cycles between acknowledge and done, are tolerated without losing or changing the transaction.
- R7: For a load, `mem_rdata` is sampled only in the done cycle. In the next cycle, `rsp_valid` is 1 for exactly one cycle with that word on `rsp_rdata`. A store never raises `rsp_valid`.
- R8: In the cycle after done, `mem_req`, `mem_rd` and `mem_wr` are 0 and `cmd_ready` is 1. The next request therefore comes no earlier than one cycle after that.
- R9: While `rst_n` is 0, `mem_req`, `mem_rd`, `mem_wr` and `rsp_valid` are 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command taken on this edge if valid |
| cmd_write | input | 1 | 1 = store, 0 = load |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | One-cycle load result strobe |
| rsp_rdata | output | DATA_W | Load result |
| mem_req | output | 1 | Access request to memory |
| mem_acq | input | 1 | Memory grants access |
| mem_addr | output | ADDR_W | Transaction address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DATA_W | Store data toward memory |
| mem_rdata | input | DATA_W | Load data from memory, valid in the done cycle |
| mem_done | input | 1 | Memory finished the transaction |

## Verification
The bench sweeps grant and completion latencies from zero upward and includes the case where grant and done arrive together. A design that waited for a separate done cycle after the grant would hang there. The memory model drives a wrong word on the read bus in every cycle except the done cycle. A requester that sampled one cycle late or early would therefore return corrupted loads. Stores followed by loads to the same address show whether the write data and strobe were held correctly. The cycle after each done is checked for released strobes, which catches a design that starts a back-to-back request too soon.

// File: rtl/mar_pkg.sv
package mar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_REQUEST  = 2'd1,
        ST_TRANSFER = 2'd2
    } mar_state_e;
endpackage

// File: rtl/mar_fsm.sv
module mar_fsm
    import mar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic mem_acq,
    input  logic mem_done,
    output logic cmd_ready,
    output logic req_out,
    output logic xact_active,
    output logic accept,
    output logic finish
);
    mar_state_e state_q;
    mar_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: ACCEPT, GRANT_WAIT, GRANT, FAST_FINISH, DONE_WAIT, FINISH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (cmd_valid) state_d = ST_REQUEST;
            ST_REQUEST: begin
                if (mem_acq && mem_done) state_d = ST_IDLE;
                else if (mem_acq)        state_d = ST_TRANSFER;
            end
            ST_TRANSFER: if (mem_done) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready   = 1'b0;
        req_out     = 1'b0;
        xact_active = 1'b0;
        accept      = 1'b0;
        finish      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                accept    = cmd_valid;
            end
            ST_REQUEST: begin
                req_out     = 1'b1;
                xact_active = 1'b1;
                finish      = mem_acq && mem_done;
            end
            ST_TRANSFER: begin
                xact_active = 1'b1;
                finish      = mem_done;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mar_cmd_hold.sv
module mar_cmd_hold #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              out_write,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_wdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_write <= 1'b0;
            out_addr  <= '0;
            out_wdata <= '0;
        end else if (load_en) begin
            out_write <= in_write;
            out_addr  <= in_addr;
            out_wdata <= in_wdata;
        end
    end
endmodule

// File: rtl/mar_load_capture.sv
module mar_load_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_rdata <= bus_data;
        end
    end
endmodule

// File: rtl/mem_access_requester.sv
module mem_access_requester #(
    parameter int DATA_W    = 8,
    parameter int MEM_DEPTH = 10,
    parameter int ADDR_W    = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req,
    input  logic              mem_acq,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_done
);
    logic xact_active;
    logic accept;
    logic finish;
    logic hold_write;

    mar_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .mem_acq     (mem_acq),
        .mem_done    (mem_done),
        .cmd_ready   (cmd_ready),
        .req_out     (mem_req),
        .xact_active (xact_active),
        .accept      (accept),
        .finish      (finish)
    );

    mar_cmd_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (accept),
        .in_write  (cmd_write),
        .in_addr   (cmd_addr),
        .in_wdata  (cmd_wdata),
        .out_write (hold_write),
        .out_addr  (mem_addr),
        .out_wdata (mem_wdata)
    );

    // exactly one strobe per transaction (R4)
    assign mem_rd = xact_active && !hold_write;
    assign mem_wr = xact_active &&  hold_write;

    mar_load_capture #(.DATA_W(DATA_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (finish && !hold_write),
        .bus_data  (mem_rdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );
endmodule

// File: rtl/mar_checker.sv
module mar_checker #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              mem_req,
    input logic              mem_acq,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata
);
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_acq) |=> mem_req);

    a_r3_xact_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && !mem_done) |=>
            ($stable(mem_addr) && $stable(mem_rd) && $stable(mem_wr) && $stable(mem_wdata)));

    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones({mem_rd, mem_wr}) == 1));

    a_r7_load_result: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_done) |=> (rsp_valid && rsp_rdata == $past(mem_rdata)));

    a_r7_store_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_done) |=> !rsp_valid);

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && mem_done) |=> (!mem_req && !mem_rd && !mem_wr && cmd_ready));

    a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!mem_req && !mem_rd && !mem_wr));
endmodule

bind mem_access_requester mar_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .mem_req   (mem_req),
    .mem_acq   (mem_acq),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_done  (mem_done),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
);

// File: tb/test_mem_access_requester.sv
module test_mem_access_requester;
    localparam int DW    = 8;
    localparam int DEPTH = 10;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic cmd_ready, rsp_valid, mem_req, mem_rd, mem_wr;
    logic [DW-1:0] rsp_rdata, mem_wdata;
    logic [AW-1:0] mem_addr;
    logic mem_acq = 1'b0, mem_done = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    always #10 clk = ~clk;

    mem_access_requester #(.DATA_W(DW), .MEM_DEPTH(DEPTH)) i_mem_access_requester (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_req(mem_req),
        .mem_acq(mem_acq), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done)
    );

    int checks = 0, failures = 0;
    int done_count = 0, rsp_count = 0, load_count = 0;
    int ack_lat = 0, done_lat = 0;
    logic [DW-1:0] model_mem [0:(1<<AW)-1];
    logic [DW-1:0] shadow_mem [0:(1<<AW)-1];
    logic [DW-1:0] exp_q [$];
    logic exp_write = 1'b0;
    logic [AW-1:0] exp_addr = '0;
    logic [DW-1:0] exp_wdata = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory model: configurable grant and completion latency
    int phase = 0, cnt = 0;
    bit after_done = 0;
    task automatic finish_xact();
        mem_done = 1'b1;
        chk(mem_addr == exp_addr, "R3", "address at done", 32'(mem_addr), 32'(exp_addr));
        chk(mem_wr == exp_write && mem_rd == !exp_write, "R4", "strobes at done",
            {30'd0, mem_rd, mem_wr}, {30'd0, !exp_write, exp_write});
        if (exp_write)
            chk(mem_wdata == exp_wdata, "R3", "store data at done", 32'(mem_wdata), 32'(exp_wdata));
        if (mem_wr && !mem_rd) model_mem[mem_addr] = mem_wdata;
        mem_rdata = model_mem[mem_addr];
        phase = 0; cnt = 0; after_done = 1; done_count++;
    endtask

    always @(negedge clk) begin
        mem_acq  = 1'b0;
        mem_done = 1'b0;
        mem_rdata = ~model_mem[mem_addr];  // wrong word outside the done cycle (R7)
        if (after_done) begin
            after_done = 0;
            chk(!mem_req && !mem_rd && !mem_wr && cmd_ready, "R8", "release after done",
                {28'd0, mem_req, mem_rd, mem_wr, cmd_ready}, 32'd1);
        end else if (rst_n && (phase != 0 || mem_req)) begin
            chk(!cmd_ready, "R1", "ready low while busy", 32'(cmd_ready), 32'd0);
        end
        if (phase == 1) begin
            if (cnt == done_lat) finish_xact();
            else cnt++;
        end else if (phase == 0 && mem_req) begin
            if (cnt == ack_lat) begin
                mem_acq = 1'b1;
                phase = 1; cnt = 0;
                if (done_lat == 0) finish_xact();   // R5 grant and done together
            end else begin
                cnt++;
            end
        end
    end

    // scoreboard monitor (R7)
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            rsp_count++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7", "unexpected response", 32'(rsp_rdata), 32'd0);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                chk(rsp_rdata == e, "R7", "load data", 32'(rsp_rdata), 32'(e));
            end
        end
    end

    task automatic do_cmd(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int start;
        bit was_ready;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
        exp_write = wr; exp_addr = a; exp_wdata = d;
        if (wr) shadow_mem[a] = d;
        else begin exp_q.push_back(shadow_mem[a]); load_count++; end
        start = done_count;
        forever begin
            was_ready = cmd_ready;
            @(posedge clk);
            if (was_ready) break;
        end
        @(negedge clk);
        cmd_valid = 1'b0; cmd_write = ~wr; cmd_addr = ~a; cmd_wdata = ~d;
        chk(mem_req || done_count != start, "R2", "request after accept", 32'(mem_req), 32'd1);
        wait (done_count != start);
    endtask

    initial begin
        for (int i = 0; i < (1<<AW); i++) begin
            model_mem[i] = DW'(i * 17 + 3);
            shadow_mem[i] = DW'(i * 17 + 3);
        end
        cmd_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk(!mem_req && !mem_rd && !mem_wr && !rsp_valid && cmd_ready, "R9", "reset state",
            {27'd0, mem_req, mem_rd, mem_wr, rsp_valid, cmd_ready}, 32'd1);
        cmd_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready && !mem_req, "R9", "idle after reset", {30'd0, cmd_ready, mem_req}, 32'd2);
        // R5, R6: latency sweep including zero
        for (int al = 0; al < 3; al++) begin
            for (int dl = 0; dl < 4; dl++) begin
                ack_lat = al; done_lat = dl;
                do_cmd(1'b1, AW'((al * 4 + dl) % DEPTH), DW'(8'hA0 + al * 16 + dl));
                do_cmd(1'b0, AW'((al * 4 + dl) % DEPTH), '0);
                do_cmd(1'b0, AW'((al + dl + 5) % DEPTH), '0);
            end
        end
        // R6: long waits on both phases
        ack_lat = 7; done_lat = 9;
        do_cmd(1'b1, AW'(9), 8'h3C);
        do_cmd(1'b0, AW'(9), '0);
        do_cmd(1'b0, AW'(0), '0);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "all loads answered", 32'(exp_q.size()), 32'd0);
        chk(rsp_count == load_count, "R7", "response count", 32'(rsp_count), 32'(load_count));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R6 actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule